// File: doc/BRIEF.md
# Multi-Mode Timer with Overflow Interrupt

This block is one timer/counter built from two byte-wide count registers, a low byte and a high byte. A two-bit mode field chooses how the pair counts. Mode 0 is a 13-bit counter: a 5-bit prescaler in the bottom of the low byte carries into the high byte. Mode 1 is a full 16-bit cascade. Mode 2 is an 8-bit counter in the low byte that reloads from the high byte when it overflows. Mode 3 halts the timer and holds the count. A count step happens only when the run bit is set and the count-enable pulse is high in the same cycle.

Software can load either count register, the overflow flag, and a configuration word at any time. The configuration word holds the mode, the run bit, a local interrupt enable and a global interrupt enable. The interrupt request is the flag gated by both enables. An acknowledge input clears the flag when the handler is entered.

Top module: `ovf_timer`

## Requirements
- R1: After reset, both count bytes read 0, the flag and the interrupt request are 0, the mode is 0, the run bit is off and both enables are off.
- R2: In modes 0, 1 and 2 the count advances by one step only in a cycle where both the run bit and `cnt_pulse_i` are 1. When either is 0 the count holds, unless software writes it.
- R3: In mode 0 (mode code 2'b00), low-byte bits [4:0] count modulo 32. Each wrap from 31 to 0 adds one to the high byte. Low-byte bits [7:5] are never changed by counting.
- R4: In mode 0, a step taken with low-byte bits [4:0] at 31 and the high byte at 255 wraps the 13-bit count to zero and sets the flag.
- R5: In mode 1 (code 2'b01), the bytes form a 16-bit counter with the high byte on top. A step taken at 0xFFFF gives 0x0000 and sets the flag.
- R6: In mode 2 (code 2'b10), only the low byte counts. A step taken at 255 loads the low byte from the high byte and sets the flag. Counting never changes the high byte.
- R7: In mode 3 (code 2'b11), both bytes hold their value whatever the run bit and the pulse are. Software writes still apply.
- R8: A software write to a count byte takes priority over a step in the same cycle. Overflow is still judged from the values held before the write, so the flag can be set in that cycle.
- R9: Flag priority, from highest to lowest, is: an overflow sets it, then a software flag write loads it, then an acknowledge clears it. With none of these, the flag holds.
- R10: `irq_req` is 1 exactly when the flag, the local enable and the global enable are all 1.
- R11: A configuration write loads mode, run and both enables together. The new values take effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mode | input | 2 | Mode to load (00 13-bit, 01 16-bit, 10 reload, 11 halt) |
| cfg_run | input | 1 | Run bit to load |
| cfg_loc_en | input | 1 | Local interrupt enable to load |
| cfg_glb_en | input | 1 | Global interrupt enable to load |
| cnt_pulse_i | input | 1 | Count-enable pulse |
| lo_we | input | 1 | Low byte write strobe |
| lo_wdata | input | 8 | Low byte write data |
| hi_we | input | 1 | High byte write strobe |
| hi_wdata | input | 8 | High byte write data |
| flag_we | input | 1 | Flag write strobe |
| flag_wdata | input | 1 | Flag write data |
| irq_ack | input | 1 | Interrupt acknowledge, clears the flag |
| lo_q | output | 8 | Low count byte |
| hi_q | output | 8 | High count byte |
| ovf_flag | output | 1 | Overflow flag |
| irq_req | output | 1 | Gated interrupt request |

## Verification
Two kinds of same-cycle conflict matter here. The first is a hardware overflow landing in the same cycle as a software flag write or an acknowledge. The second is a count-byte write landing in the same cycle as the step that would overflow or reload that byte. The bench preloads the counters one step short of each mode's overflow point. It then fires the strobe in exactly the cycle of the wrap, in each combination. A behavioural model applies the stated priorities and is compared with all outputs after every clock, so the flag and byte values show which source won. A long random phase then mixes the same inputs at a high rate.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   typedef enum logic [1:0] {
      MODE_13BIT  = 2'b00,
      MODE_16BIT  = 2'b01,
      MODE_RELOAD = 2'b10,
      MODE_HALT   = 2'b11
   } tmr_mode_e;

   typedef struct packed {
      tmr_mode_e mode;
      logic      run;
      logic      loc_en;
      logic      glb_en;
   } tmr_cfg_t;
endpackage

// File: rtl/tmr_cfg_reg.sv
module tmr_cfg_reg
   import tmr_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     we,
   input  tmr_cfg_t wdata,
   output tmr_cfg_t cfg_q
);
   always_ff @(posedge clk) begin
      if (!rst_n)
         cfg_q <= '{mode: MODE_13BIT, run: 1'b0, loc_en: 1'b0, glb_en: 1'b0};
      else if (we)
         cfg_q <= wdata;
   end
endmodule

// File: rtl/tmr_count_next.sv
module tmr_count_next
   import tmr_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int PRE_W  = 5
) (
   input  tmr_mode_e         mode,
   input  logic              step,
   input  logic [BYTE_W-1:0] lo,
   input  logic [BYTE_W-1:0] hi,
   output logic [BYTE_W-1:0] lo_nx,
   output logic [BYTE_W-1:0] hi_nx,
   output logic              ovf
);
   localparam logic [BYTE_W-1:0] BYTE_MAX = {BYTE_W{1'b1}};
   localparam logic [PRE_W-1:0]  PRE_MAX  = {PRE_W{1'b1}};

   logic [PRE_W-1:0]  pre_inc;
   logic [BYTE_W-1:0] lo_m0;
   logic              pre_wrap;

   assign pre_inc  = lo[PRE_W-1:0] + 1'b1;
   assign pre_wrap = (lo[PRE_W-1:0] == PRE_MAX);

   generate
      if (PRE_W < 1 || PRE_W >= BYTE_W) begin : g_bad_pre
         $error("PRE_W must lie between 1 and BYTE_W-1");
      end
      for (genvar b = 0; b < BYTE_W; b++) begin : g_m0_bit
         if (b < PRE_W) begin : g_pre
            assign lo_m0[b] = pre_inc[b];
         end else begin : g_keep
            assign lo_m0[b] = lo[b];
         end
      end
   endgenerate

   always_comb begin
      lo_nx = lo;
      hi_nx = hi;
      ovf   = 1'b0;
      if (step) begin
         unique case (mode)
            MODE_13BIT: begin
               lo_nx = lo_m0;
               if (pre_wrap) begin
                  hi_nx = hi + 1'b1;
                  ovf   = (hi == BYTE_MAX);
               end
            end
            MODE_16BIT: begin
               lo_nx = lo + 1'b1;
               if (lo == BYTE_MAX) begin
                  hi_nx = hi + 1'b1;
                  ovf   = (hi == BYTE_MAX);
               end
            end
            MODE_RELOAD: begin
               if (lo == BYTE_MAX) begin
                  lo_nx = hi;
                  ovf   = 1'b1;
               end else begin
                  lo_nx = lo + 1'b1;
               end
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/tmr_flag_ctl.sv
module tmr_flag_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic ovf,
   input  logic we,
   input  logic wdata,
   input  logic ack,
   output logic flag_q
);
   always_ff @(posedge clk) begin
      if (!rst_n)     flag_q <= 1'b0;
      else if (ovf)   flag_q <= 1'b1;
      else if (we)    flag_q <= wdata;
      else if (ack)   flag_q <= 1'b0;
   end
endmodule

// File: rtl/ovf_timer.sv
module ovf_timer
   import tmr_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int PRE_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_mode,
   input  logic              cfg_run,
   input  logic              cfg_loc_en,
   input  logic              cfg_glb_en,
   input  logic              cnt_pulse_i,
   input  logic              lo_we,
   input  logic [BYTE_W-1:0] lo_wdata,
   input  logic              hi_we,
   input  logic [BYTE_W-1:0] hi_wdata,
   input  logic              flag_we,
   input  logic              flag_wdata,
   input  logic              irq_ack,
   output logic [BYTE_W-1:0] lo_q,
   output logic [BYTE_W-1:0] hi_q,
   output logic              ovf_flag,
   output logic              irq_req
);
   tmr_cfg_t          cfg_q;
   tmr_cfg_t          cfg_w;
   logic              step;
   logic              ovf_evt;
   logic [BYTE_W-1:0] lo_nx;
   logic [BYTE_W-1:0] hi_nx;

   assign cfg_w = '{mode: tmr_mode_e'(cfg_mode), run: cfg_run,
                    loc_en: cfg_loc_en, glb_en: cfg_glb_en};

   tmr_cfg_reg u_cfg (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cfg_we),
      .wdata (cfg_w),
      .cfg_q (cfg_q)
   );

   assign step = cfg_q.run & cnt_pulse_i & (cfg_q.mode != MODE_HALT);

   tmr_count_next #(.BYTE_W(BYTE_W), .PRE_W(PRE_W)) u_next (
      .mode  (cfg_q.mode),
      .step  (step),
      .lo    (lo_q),
      .hi    (hi_q),
      .lo_nx (lo_nx),
      .hi_nx (hi_nx),
      .ovf   (ovf_evt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lo_q <= '0;
         hi_q <= '0;
      end else begin
         lo_q <= lo_we ? lo_wdata : lo_nx;
         hi_q <= hi_we ? hi_wdata : hi_nx;
      end
   end

   tmr_flag_ctl u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .ovf    (ovf_evt),
      .we     (flag_we),
      .wdata  (flag_wdata),
      .ack    (irq_ack),
      .flag_q (ovf_flag)
   );

   assign irq_req = ovf_flag & cfg_q.loc_en & cfg_q.glb_en;
endmodule

// File: rtl/ovf_timer_chk.sv
module ovf_timer_chk #(
   parameter int BYTE_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        mode,
   input logic              run,
   input logic              cnt_pulse_i,
   input logic              lo_we,
   input logic              hi_we,
   input logic              flag_we,
   input logic              irq_ack,
   input logic [BYTE_W-1:0] lo_q,
   input logic [BYTE_W-1:0] hi_q,
   input logic              ovf_flag,
   input logic              irq_req
);
   localparam logic [BYTE_W-1:0] BYTE_MAX = {BYTE_W{1'b1}};

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!(run && cnt_pulse_i) && !lo_we && !hi_we) |=> ($stable(lo_q) && $stable(hi_q))); // R2
   AST_M0_TOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b00 && !lo_we) |=> $stable(lo_q[BYTE_W-1:5])); // R3
   AST_M1_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b01 && run && cnt_pulse_i && lo_q == BYTE_MAX && hi_q == BYTE_MAX) |=> ovf_flag); // R5
   AST_RELOAD_HI_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b10 && !hi_we) |=> $stable(hi_q)); // R6
   AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b11 && !lo_we && !hi_we) |=> ($stable(lo_q) && $stable(hi_q))); // R7
   AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack && !flag_we && !cnt_pulse_i) |=> !ovf_flag); // R9
   AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> ovf_flag); // R10
endmodule

bind ovf_timer ovf_timer_chk #(.BYTE_W(BYTE_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .mode        (cfg_q.mode),
   .run         (cfg_q.run),
   .cnt_pulse_i (cnt_pulse_i),
   .lo_we       (lo_we),
   .hi_we       (hi_we),
   .flag_we     (flag_we),
   .irq_ack     (irq_ack),
   .lo_q        (lo_q),
   .hi_q        (hi_q),
   .ovf_flag    (ovf_flag),
   .irq_req     (irq_req)
);

// File: tb/sim_ovf_timer.sv
`timescale 1ns/1ps
module sim_ovf_timer;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_we = 0, cfg_run = 0, cfg_loc_en = 0, cfg_glb_en = 0;
   logic [1:0] cfg_mode = 0;
   logic       cnt_pulse_i = 0, lo_we = 0, hi_we = 0, flag_we = 0, flag_wdata = 0, irq_ack = 0;
   logic [7:0] lo_wdata = 0, hi_wdata = 0;
   logic [7:0] lo_q, hi_q;
   logic       ovf_flag, irq_req;

   int  n_cmp = 0, n_bad = 0;
   bit  done = 0;
   string tag = "R1";

   int m_lo, m_hi, m_flag, m_mode, m_run, m_le, m_ge;

   always #2.5 clk = ~clk;

   ovf_timer u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mode(cfg_mode), .cfg_run(cfg_run),
      .cfg_loc_en(cfg_loc_en), .cfg_glb_en(cfg_glb_en), .cnt_pulse_i(cnt_pulse_i),
      .lo_we(lo_we), .lo_wdata(lo_wdata), .hi_we(hi_we), .hi_wdata(hi_wdata),
      .flag_we(flag_we), .flag_wdata(flag_wdata), .irq_ack(irq_ack),
      .lo_q(lo_q), .hi_q(hi_q), .ovf_flag(ovf_flag), .irq_req(irq_req)
   );

   // behavioural reference, updated at each rising edge from inputs held since the last one
   always @(posedge clk) begin
      int nlo, nhi, ov;
      if (!rst_n) begin
         m_lo = 0; m_hi = 0; m_flag = 0; m_mode = 0; m_run = 0; m_le = 0; m_ge = 0;
      end else begin
         nlo = m_lo; nhi = m_hi; ov = 0;
         if (m_run == 1 && cnt_pulse_i && m_mode != 3) begin
            if (m_mode == 0) begin
               if (m_lo % 32 == 31) begin
                  nlo = (m_lo / 32) * 32;
                  if (m_hi == 255) begin nhi = 0; ov = 1; end else nhi = m_hi + 1;
               end else nlo = m_lo + 1;
            end else if (m_mode == 1) begin
               if (m_lo == 255) begin
                  nlo = 0;
                  if (m_hi == 255) begin nhi = 0; ov = 1; end else nhi = m_hi + 1;
               end else nlo = m_lo + 1;
            end else begin
               if (m_lo == 255) begin nlo = m_hi; ov = 1; end else nlo = m_lo + 1;
            end
         end
         if (lo_we) nlo = lo_wdata;
         if (hi_we) nhi = hi_wdata;
         if (ov == 1) m_flag = 1;
         else if (flag_we) m_flag = flag_wdata;
         else if (irq_ack) m_flag = 0;
         if (cfg_we) begin
            m_mode = cfg_mode; m_run = cfg_run; m_le = cfg_loc_en; m_ge = cfg_glb_en;
         end
         m_lo = nlo; m_hi = nhi;
      end
   end

   task automatic check1(string what, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      check1("lo_q", lo_q, m_lo);
      check1("hi_q", hi_q, m_hi);
      check1("ovf_flag", ovf_flag, m_flag);
      check1("irq_req", irq_req, (m_flag == 1 && m_le == 1 && m_ge == 1) ? 1 : 0); // R10
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
      compare_all();
      cfg_we = 0; lo_we = 0; hi_we = 0; flag_we = 0; irq_ack = 0;
   endtask

   task automatic set_cfg(int md, int rn, int le, int ge);
      cfg_we = 1; cfg_mode = md[1:0]; cfg_run = rn[0]; cfg_loc_en = le[0]; cfg_glb_en = ge[0];
      tick();
   endtask

   task automatic load(int lo, int hi);
      lo_we = 1; lo_wdata = lo[7:0]; hi_we = 1; hi_wdata = hi[7:0];
      tick();
   endtask

   task automatic pulses(int n);
      for (int i = 0; i < n; i++) begin
         cnt_pulse_i = 1;
         tick();
      end
      cnt_pulse_i = 0;
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      tag = "R1";
      repeat (3) @(posedge clk);
      #1;
      compare_all();
      rst_n = 1;
      tick();

      tag = "R11";
      set_cfg(1, 1, 0, 0);
      tick();

      tag = "R5";
      load(8'hF0, 8'hFF);
      pulses(20);

      tag = "R2";
      set_cfg(1, 0, 0, 0);
      pulses(10);
      set_cfg(1, 1, 0, 0);
      for (int i = 0; i < 12; i++) begin
         cnt_pulse_i = i[0];
         tick();
      end
      cnt_pulse_i = 0;

      tag = "R3";
      flag_we = 1; flag_wdata = 0; tick();
      set_cfg(0, 1, 0, 0);
      load(8'hE3, 8'h10);
      pulses(70);

      tag = "R4";
      load(8'hBD, 8'hFF);
      pulses(5);

      tag = "R6";
      set_cfg(2, 1, 1, 1);
      load(8'hFD, 8'hF0);
      pulses(40);
      hi_we = 1; hi_wdata = 8'h80; cnt_pulse_i = 1; tick();
      pulses(140);

      tag = "R7";
      set_cfg(3, 1, 1, 1);
      pulses(10);
      set_cfg(3, 0, 1, 1);
      pulses(5);
      load(8'h12, 8'h34);
      pulses(3);

      tag = "R8";
      set_cfg(1, 1, 1, 1);
      flag_we = 1; flag_wdata = 0; tick();
      load(8'hFF, 8'hFF);
      lo_we = 1; lo_wdata = 8'h55; cnt_pulse_i = 1; tick();
      cnt_pulse_i = 0;
      set_cfg(2, 1, 1, 1);
      load(8'hFF, 8'h20);
      hi_we = 1; hi_wdata = 8'h99; cnt_pulse_i = 1; tick();
      cnt_pulse_i = 0;

      tag = "R9";
      flag_we = 1; flag_wdata = 0; tick();
      load(8'hFF, 8'h00);
      flag_we = 1; flag_wdata = 0; cnt_pulse_i = 1; tick();
      cnt_pulse_i = 0;
      load(8'hFF, 8'h00);
      irq_ack = 1; cnt_pulse_i = 1; tick();
      cnt_pulse_i = 0;
      irq_ack = 1; flag_we = 1; flag_wdata = 1; tick();
      irq_ack = 1; tick();
      flag_we = 1; flag_wdata = 1; tick();

      tag = "R10";
      for (int e = 0; e < 4; e++) begin
         set_cfg(2, 0, e & 1, e >> 1);
         tick();
      end

      tag = "R2";
      for (int i = 0; i < 6000; i++) begin
         cfg_we      = ($urandom_range(0, 40) == 0);
         cfg_mode    = 2'($urandom_range(0, 3));
         cfg_run     = ($urandom_range(0, 7) != 0);
         cfg_loc_en  = 1'($urandom_range(0, 1));
         cfg_glb_en  = 1'($urandom_range(0, 1));
         cnt_pulse_i = ($urandom_range(0, 3) != 0);
         lo_we       = ($urandom_range(0, 30) == 0);
         lo_wdata    = ($urandom_range(0, 1) == 1) ? 8'hFF : 8'($urandom_range(0, 255));
         hi_we       = ($urandom_range(0, 30) == 0);
         hi_wdata    = ($urandom_range(0, 1) == 1) ? 8'hFF : 8'($urandom_range(0, 255));
         flag_we     = ($urandom_range(0, 15) == 0);
         flag_wdata  = 1'($urandom_range(0, 1));
         irq_ack     = ($urandom_range(0, 7) == 0);
         tick();
      end
      cnt_pulse_i = 0;

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule